// File: doc/BRIEF.md
# Secure Privileged Register Gate

This block stands in front of a small bank of power-control registers and judges every write by the security and privilege attributes of the bus transaction that carries it. It holds four configuration cells:

- a secure-world privilege bit;
- a non-secure-world privilege bit;
- a low-power security bit, which says which world owns the low-power controls;
- a backup-domain unlock bit.

It also keeps the stop and standby status flags. Each write is either accepted or silently dropped. The bus sees no error in either case; a one-cycle pulse on one of two outputs records the outcome.

Writes to the upper half of the address space target backup-domain registers that live outside the block. The gate passes them on as a registered strobe with address and data, but only while the unlock bit is set. A write-one command cell clears both status flags at once. Hardware set pulses raise the flags, and a set pulse beats a clear that lands in the same cycle.

The two flags are held by a four-state machine:

| State | Meaning |
|-------|---------|
| FL_CLEAR | neither flag set |
| FL_STOP | stop flag only |
| FL_STBY | standby flag only |
| FL_BOTH | both flags set |

Transitions are named by their cause:

| Transition | Effect |
|------------|--------|
| set-stop | adds the stop flag |
| set-standby | adds the standby flag |
| clear | returns to FL_CLEAR |
| clear-with-set | ends in the state made of only the flags being set in that cycle |
| hold | stays put when nothing happens |

Top module: `sec_priv_reg_gate`

## Requirements
- R1: After reset all four configuration cells read 0, both flags are 0, and no accept, reject or backup strobe is asserted.
- R2: The secure-privilege cell (address 0, data bit 0) is written only by an access that is both secure and privileged.
- R3: The non-secure-privilege cell (address 1, data bit 0) is written by any privileged access, secure or non-secure.
- R4: The low-power security cell (address 2, data bit 0) is written only by a secure access that is privileged or finds the secure-privilege cell at 0.
- R5: While the low-power security cell is 1, the flag-clear command (address 4) and the unlock cell (address 3, data bit 0) reject non-secure writes, and reject unprivileged writes when the secure-privilege cell is 1.
- R6: While the low-power security cell is 0, addresses 3 and 4 ignore the secure attribute and reject unprivileged writes only when the non-secure-privilege cell is 1.
- R7: An accepted write to address 4 with data bit 0 equal to 1 clears both flags; with data bit 0 equal to 0 it is accepted and changes nothing.
- R8: A set pulse raises its flag one cycle later; a set pulse in the same cycle as an accepted clear wins for its own flag.
- R9: A write with the top address bit set is accepted only while the unlock cell is 1. It then produces a one-cycle backup strobe carrying the low address bits and the full data; otherwise it is rejected with no strobe.
- R10: Every write gives exactly one accept or reject pulse in the next cycle. Addresses 5 to 7 are always rejected, and a rejected write changes no cell and no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request this cycle |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | DATA_W | Write data |
| wr_secure | input | 1 | Transaction is from the secure world |
| wr_priv | input | 1 | Transaction is privileged |
| set_stop | input | 1 | Hardware pulse raising the stop flag |
| set_stby | input | 1 | Hardware pulse raising the standby flag |
| wr_accept | output | 1 | One-cycle pulse: last write accepted |
| wr_reject | output | 1 | One-cycle pulse: last write dropped |
| bkp_wr_stb | output | 1 | One-cycle strobe for a passed backup write |
| bkp_wr_addr | output | ADDR_W-1 | Backup register index |
| bkp_wr_data | output | DATA_W | Backup write data |
| cfg_sec_priv | output | 1 | Secure-privilege cell |
| cfg_ns_priv | output | 1 | Non-secure-privilege cell |
| cfg_lp_sec | output | 1 | Low-power security cell |
| cfg_bkp_unlock | output | 1 | Backup unlock cell |
| stop_flag | output | 1 | Stop flag |
| stby_flag | output | 1 | Standby flag |

## Verification
Every result of a write taken on a rising edge is due one cycle later: the accept or reject pulse, the backup strobe, and the new cell or flag values all appear after that same edge. A set pulse shows up in its flag on the same schedule. The bench drives each input on a falling edge and compares everything on the next falling edge, which sits halfway into the cycle in which the results are valid. The sweep restores a chosen configuration before every probe, so each expected outcome is computed from a known starting point.

// File: rtl/gate_pkg.sv
package gate_pkg;

    typedef enum logic [1:0] {
        FL_CLEAR = 2'd0,
        FL_STOP  = 2'd1,
        FL_STBY  = 2'd2,
        FL_BOTH  = 2'd3
    } flag_state_e;

    typedef enum logic [2:0] {
        T_SPRIV  = 3'd0,
        T_NSPRIV = 3'd1,
        T_LPSEC  = 3'd2,
        T_UNLOCK = 3'd3,
        T_FCLR   = 3'd4,
        T_BKPREG = 3'd5,
        T_NONE   = 3'd6
    } target_e;

    typedef struct packed {
        logic sp;
        logic nsp;
        logic lps;
        logic unlock;
    } gate_cfg_t;

endpackage

// File: rtl/gate_decode.sv
module gate_decode
    import gate_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              secure,
    input  logic              priv,
    input  gate_cfg_t         cfg,
    output target_e           target,
    output logic              allow
);
    localparam int TOP  = ADDR_W - 1;
    localparam int LOWW = ADDR_W - 1;

    logic [LOWW-1:0] low;
    logic            lp_ok;

    assign low = addr[LOWW-1:0];

    always_comb begin
        target = T_NONE;
        if (addr[TOP]) begin
            target = T_BKPREG;
        end else if (low == LOWW'(0)) begin
            target = T_SPRIV;
        end else if (low == LOWW'(1)) begin
            target = T_NSPRIV;
        end else if (low == LOWW'(2)) begin
            target = T_LPSEC;
        end else if (low == LOWW'(3)) begin
            target = T_UNLOCK;
        end else if (low == LOWW'(4)) begin
            target = T_FCLR;
        end
    end

    // The world that owns the low-power controls decides the rule.
    assign lp_ok = cfg.lps ? (secure && (!cfg.sp || priv))
                           : (!cfg.nsp || priv);

    always_comb begin
        unique case (target)
            T_SPRIV:  allow = secure && priv;
            T_NSPRIV: allow = priv;
            T_LPSEC:  allow = secure && (!cfg.sp || priv);
            T_UNLOCK: allow = lp_ok;
            T_FCLR:   allow = lp_ok;
            T_BKPREG: allow = cfg.unlock;
            default:  allow = 1'b0;
        endcase
    end

endmodule

// File: rtl/gate_cfg_regs.sv
module gate_cfg_regs
    import gate_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_ok,
    input  target_e   target,
    input  logic      d0,
    output gate_cfg_t cfg
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_ok) begin
            unique case (target)
                T_SPRIV:  cfg.sp     <= d0;
                T_NSPRIV: cfg.nsp    <= d0;
                T_LPSEC:  cfg.lps    <= d0;
                T_UNLOCK: cfg.unlock <= d0;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/gate_flag_fsm.sv
module gate_flag_fsm
    import gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_stop,
    input  logic set_stby,
    input  logic clr_cmd,
    output logic stop_flag,
    output logic stby_flag
);
    flag_state_e state_q, state_d;
    logic        keep_stop, keep_stby;

    always_comb begin
        keep_stop = 1'b0;
        keep_stby = 1'b0;
        unique case (state_q)
            FL_CLEAR: begin keep_stop = 1'b0; keep_stby = 1'b0; end
            FL_STOP:  begin keep_stop = 1'b1; keep_stby = 1'b0; end
            FL_STBY:  begin keep_stop = 1'b0; keep_stby = 1'b1; end
            FL_BOTH:  begin keep_stop = 1'b1; keep_stby = 1'b1; end
        endcase
        if (clr_cmd) begin
            keep_stop = 1'b0;
            keep_stby = 1'b0;
        end
        // Set pulses are applied after the clear, so they win.
        state_d = flag_state_e'({keep_stby | set_stby, keep_stop | set_stop});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            FL_CLEAR: begin stop_flag = 1'b0; stby_flag = 1'b0; end
            FL_STOP:  begin stop_flag = 1'b1; stby_flag = 1'b0; end
            FL_STBY:  begin stop_flag = 1'b0; stby_flag = 1'b1; end
            FL_BOTH:  begin stop_flag = 1'b1; stby_flag = 1'b1; end
        endcase
    end

    // R8: a set pulse always shows in its flag on the next cycle
    a_r8_stop_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_stop |=> stop_flag);
    a_r8_stby_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_stby |=> stby_flag);
    // R7: a clear without a set pulse leaves the flags low
    a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cmd && !set_stop && !set_stby) |=> (!stop_flag && !stby_flag));

endmodule

// File: rtl/sec_priv_reg_gate.sv
module sec_priv_reg_gate
    import gate_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_secure,
    input  logic              wr_priv,
    input  logic              set_stop,
    input  logic              set_stby,
    output logic              wr_accept,
    output logic              wr_reject,
    output logic              bkp_wr_stb,
    output logic [ADDR_W-2:0] bkp_wr_addr,
    output logic [DATA_W-1:0] bkp_wr_data,
    output logic              cfg_sec_priv,
    output logic              cfg_ns_priv,
    output logic              cfg_lp_sec,
    output logic              cfg_bkp_unlock,
    output logic              stop_flag,
    output logic              stby_flag
);
    localparam int IDXW = ADDR_W - 1;

    gate_cfg_t cfg;
    target_e   target;
    logic      allow, wr_ok, clr_cmd;

    gate_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr   (wr_addr),
        .secure (wr_secure),
        .priv   (wr_priv),
        .cfg    (cfg),
        .target (target),
        .allow  (allow)
    );

    assign wr_ok   = wr_en && allow;
    assign clr_cmd = wr_ok && (target == T_FCLR) && wr_data[0];

    gate_cfg_regs u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ok  (wr_ok),
        .target (target),
        .d0     (wr_data[0]),
        .cfg    (cfg)
    );

    gate_flag_fsm u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_stop  (set_stop),
        .set_stby  (set_stby),
        .clr_cmd   (clr_cmd),
        .stop_flag (stop_flag),
        .stby_flag (stby_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_accept   <= 1'b0;
            wr_reject   <= 1'b0;
            bkp_wr_stb  <= 1'b0;
            bkp_wr_addr <= '0;
            bkp_wr_data <= '0;
        end else begin
            wr_accept  <= wr_ok;
            wr_reject  <= wr_en && !allow;
            bkp_wr_stb <= wr_ok && (target == T_BKPREG);
            if (wr_ok && (target == T_BKPREG)) begin
                bkp_wr_addr <= wr_addr[IDXW-1:0];
                bkp_wr_data <= wr_data;
            end
        end
    end

    assign cfg_sec_priv   = cfg.sp;
    assign cfg_ns_priv    = cfg.nsp;
    assign cfg_lp_sec     = cfg.lps;
    assign cfg_bkp_unlock = cfg.unlock;

    // R10: never both outcomes at once
    a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_accept && wr_reject));
    // R10: each write request leads to one outcome pulse
    a_r10_outcome_due: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (wr_accept || wr_reject));
    // R10: a rejected write leaves every configuration cell unchanged
    a_r10_reject_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        wr_reject |-> ($stable(cfg_sec_priv) && $stable(cfg_ns_priv)
                       && $stable(cfg_lp_sec) && $stable(cfg_bkp_unlock)));
    // R2: secure-privilege cell moves only after a secure privileged write
    a_r2_spriv_guard: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_sec_priv) |-> $past(wr_en && wr_secure && wr_priv));
    // R3: non-secure-privilege cell moves only after a privileged write
    a_r3_nspriv_guard: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_ns_priv) |-> $past(wr_en && wr_priv));
    // R9: backup strobe only while the unlock cell was set
    a_r9_bkp_needs_unlock: assert property (@(posedge clk) disable iff (!rst_n)
        bkp_wr_stb |-> ($past(cfg_bkp_unlock) && wr_accept));

endmodule

// File: tb/sec_priv_reg_gate_bench.sv
`timescale 1ns/1ps
module sec_priv_reg_gate_bench;
    localparam int AW = 4;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_secure = 1'b0;
    logic          wr_priv = 1'b0;
    logic          set_stop = 1'b0;
    logic          set_stby = 1'b0;
    logic          wr_accept, wr_reject, bkp_wr_stb;
    logic [AW-2:0] bkp_wr_addr;
    logic [DW-1:0] bkp_wr_data;
    logic          cfg_sec_priv, cfg_ns_priv, cfg_lp_sec, cfg_bkp_unlock;
    logic          stop_flag, stby_flag;

    int checks = 0;
    int errors = 0;

    logic m_sp = 0, m_nsp = 0, m_lps = 0, m_un = 0, m_stop = 0, m_stby = 0;

    always #2.5 clk = ~clk;

    sec_priv_reg_gate #(.ADDR_W(AW), .DATA_W(DW)) u_sec_priv_reg_gate (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_secure(wr_secure), .wr_priv(wr_priv),
        .set_stop(set_stop), .set_stby(set_stby), .wr_accept(wr_accept),
        .wr_reject(wr_reject), .bkp_wr_stb(bkp_wr_stb),
        .bkp_wr_addr(bkp_wr_addr), .bkp_wr_data(bkp_wr_data),
        .cfg_sec_priv(cfg_sec_priv), .cfg_ns_priv(cfg_ns_priv),
        .cfg_lp_sec(cfg_lp_sec), .cfg_bkp_unlock(cfg_bkp_unlock),
        .stop_flag(stop_flag), .stby_flag(stby_flag)
    );

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic exp_allow(input int a, input logic s, input logic p);
        logic lp;
        lp = m_lps ? (s && (!m_sp || p)) : (!m_nsp || p);
        if (a >= 8) return m_un;
        case (a)
            0: return s && p;
            1: return p;
            2: return s && (!m_sp || p);
            3: return lp;
            4: return lp;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(input int a);
        if (a >= 8) return "R9";
        case (a)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3, 4: return m_lps ? "R5" : "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic check_state(input string req);
        chk(req, "sec_priv", {31'd0, cfg_sec_priv}, {31'd0, m_sp});
        chk(req, "ns_priv", {31'd0, cfg_ns_priv}, {31'd0, m_nsp});
        chk(req, "lp_sec", {31'd0, cfg_lp_sec}, {31'd0, m_lps});
        chk(req, "unlock", {31'd0, cfg_bkp_unlock}, {31'd0, m_un});
        chk(req, "stop", {31'd0, stop_flag}, {31'd0, m_stop});
        chk(req, "stby", {31'd0, stby_flag}, {31'd0, m_stby});
    endtask

    // Drives on a falling edge; results are compared one falling edge later.
    task automatic do_write(input int a, input logic [DW-1:0] d,
                            input logic s, input logic p,
                            input logic sst, input logic ssb);
        logic  ok;
        string rq;
        ok = exp_allow(a, s, p);
        rq = req_of(a);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        wr_secure = s; wr_priv = p; set_stop = sst; set_stby = ssb;
        if (ok) begin
            case (a)
                0: m_sp = d[0];
                1: m_nsp = d[0];
                2: m_lps = d[0];
                3: m_un = d[0];
                4: if (d[0]) begin m_stop = 1'b0; m_stby = 1'b0; end
                default: ;
            endcase
        end
        if (sst) m_stop = 1'b1;
        if (ssb) m_stby = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; set_stop = 1'b0; set_stby = 1'b0;
        chk(rq, "accept", {31'd0, wr_accept}, {31'd0, ok});
        chk("R10", "reject", {31'd0, wr_reject}, {31'd0, !ok});
        chk(rq, "bkp_stb", {31'd0, bkp_wr_stb}, {31'd0, ok && (a >= 8)});
        if (ok && a >= 8) begin
            chk("R9", "bkp_addr", {29'd0, bkp_wr_addr}, DW'(a % 8));
            chk("R9", "bkp_data", bkp_wr_data, d);
        end
        check_state(a == 4 ? "R7" : rq);
    endtask

    task automatic raise_flags();
        set_stop = 1'b1; set_stby = 1'b1;
        @(negedge clk);
        set_stop = 1'b0; set_stby = 1'b0;
        m_stop = 1'b1; m_stby = 1'b1;
        check_state("R8");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int k;
        k = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_state("R1");
        chk("R1", "accept", {31'd0, wr_accept}, 32'd0);
        chk("R1", "reject", {31'd0, wr_reject}, 32'd0);
        chk("R1", "bkp_stb", {31'd0, bkp_wr_stb}, 32'd0);

        // R9: backup write while locked is dropped
        do_write(9, 32'h1234_5678, 1'b1, 1'b1, 1'b0, 1'b0);

        // Sweep over configuration x address x attributes
        for (int c = 0; c < 16; c++) begin
            for (int t = 0; t < 16; t++) begin
                for (int at = 0; at < 4; at++) begin
                    do_write(0, DW'(c & 1), 1'b1, 1'b1, 1'b0, 1'b0);
                    do_write(1, DW'((c >> 1) & 1), 1'b1, 1'b1, 1'b0, 1'b0);
                    do_write(2, DW'((c >> 2) & 1), 1'b1, 1'b1, 1'b0, 1'b0);
                    do_write(3, DW'((c >> 3) & 1), 1'b1, 1'b1, 1'b0, 1'b0);
                    raise_flags();
                    k++;
                    do_write(t, {16'hC0DE, 8'(k), 7'd0, 1'((k % 3) != 0)},
                             1'(at & 1), 1'(at >> 1), 1'b0, 1'b0);
                end
            end
        end

        // R8: set pulse arriving together with an accepted clear wins
        do_write(2, 32'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        do_write(1, 32'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        raise_flags();
        do_write(4, 32'd1, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R8", "stop kept", {31'd0, stop_flag}, 32'd1);
        chk("R8", "stby cleared", {31'd0, stby_flag}, 32'd0);
        raise_flags();
        do_write(4, 32'd1, 1'b1, 1'b0, 1'b0, 1'b1);
        chk("R8", "stby kept", {31'd0, stby_flag}, 32'd1);
        chk("R8", "stop cleared", {31'd0, stop_flag}, 32'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule